// File: doc/BRIEF.md
# Complementary PWM Phase Generator with Dead Time

This block drives the two switches of one motor half-bridge. It takes the value and the direction of a shared up/down triangle counter, together with three compare values: one used while counting up, one used while counting down, and one shared by both intervals. From these it derives two raw compare waveforms, one for each leg.

When a raw waveform falls, a dead-time counter starts. While that counter runs, the opposite leg cannot turn on. Each final leg is its own raw waveform gated by the dead-time window of the other leg. A per-leg level bit then sets the polarity at the pin.

The triangle counter lives outside the block. The block reacts only to the values presented on its ports, one clock cycle at a time.

Top module: `cpwm_phase_gen`

## Requirements
- R1: With `cnt_up` = 1 (counting up), raw positive leg is 1 when `tri_cnt` >= `cmp_up`, and 0 when `cmp_up` > `tri_cnt`.
- R2: With `cnt_up` = 0 (counting down), raw positive leg is 1 when `tri_cnt` >= `cmp_mid`, and 0 otherwise.
- R3: With `cnt_up` = 1, raw negative leg is 1 when `cmp_mid` > `tri_cnt`, and 0 otherwise.
- R4: With `cnt_up` = 0, raw negative leg is 1 when `cmp_dn` > `tri_cnt`, and 0 otherwise.
- R5: With no dead time active, the pins follow the compare result of the inputs that were present before a clock edge. The change appears after the second rising edge, counted from the edge that captures those inputs.
- R6: A falling edge of the raw negative leg, with `dead_len` = L > 0, holds the final positive leg at 0 for exactly L output cycles. The first of those cycles is the one in which the positive leg could first have risen. With L = 0 there is no delay.
- R7: The same rule applies the other way round: a falling edge of the raw positive leg holds the final negative leg at 0 for exactly L output cycles.
- R8: A new falling edge that arrives while a dead-time window is still running restarts that window at its full length L.
- R9: `pwm_pos` equals the final positive leg when `lvl_pos` = 1, and its inverse when `lvl_pos` = 0. `lvl_neg` sets `pwm_neg` the same way.
- R10: A synchronous active-high `rst` sets both final legs to 0, so each pin shows its inactive level. It also abandons any dead-time window in progress.
- R11: A final leg is 1 only if its own raw leg was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tri_cnt | input | CNT_W | Triangle counter value |
| cnt_up | input | 1 | 1 = counting up, 0 = counting down |
| cmp_up | input | CNT_W | Compare value for the up interval |
| cmp_mid | input | CNT_W | Compare value shared by both intervals |
| cmp_dn | input | CNT_W | Compare value for the down interval |
| dead_len | input | DT_W | Dead-time length in clock cycles |
| lvl_pos | input | 1 | Positive-leg polarity (1 = active high) |
| lvl_neg | input | 1 | Negative-leg polarity (1 = active high) |
| pwm_pos | output | 1 | Positive-leg pin |
| pwm_neg | output | 1 | Negative-leg pin |

## Verification
The hardest case to reach is a second falling edge on the same leg while its dead-time window is still running. Producing it requires the raw leg to fall, rise and fall again within fewer than L cycles.

The bench does this by stepping the counter value directly. It places the counter above the middle compare value, then below it, back above for a single cycle, and below once more. It then counts the cycles until the opposite pin is released and checks that number against a window measured from the second edge rather than the first.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int CNT_W_DEF = 16;
    localparam int DT_W_DEF  = 16;
    localparam int LEGS      = 2;
    localparam int LEG_POS   = 0;
    localparam int LEG_NEG   = 1;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } leg_pair_t;

    // Select raw leg levels from the three "compare above counter" flags.
    function automatic leg_pair_t pick_legs(
        input cnt_dir_e dir,
        input logic     up_above,
        input logic     mid_above,
        input logic     dn_above
    );
        leg_pair_t r;
        if (dir == DIR_UP) begin
            r.pos = ~up_above;
            r.neg = mid_above;
        end else begin
            r.pos = ~mid_above;
            r.neg = dn_above;
        end
        return r;
    endfunction

endpackage

// File: rtl/cpwm_compare.sv
module cpwm_compare
    import cpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tri_cnt,
    input  logic             cnt_up,
    input  logic [CNT_W-1:0] cmp_up,
    input  logic [CNT_W-1:0] cmp_mid,
    input  logic [CNT_W-1:0] cmp_dn,
    output leg_pair_t        raw_q
);

    logic      up_above;
    logic      mid_above;
    logic      dn_above;
    cnt_dir_e  dir;
    leg_pair_t raw_d;

    always_comb begin
        up_above  = cmp_up  > tri_cnt;
        mid_above = cmp_mid > tri_cnt;
        dn_above  = cmp_dn  > tri_cnt;
        dir       = cnt_up ? DIR_UP : DIR_DOWN;
        raw_d     = pick_legs(dir, up_above, mid_above, dn_above);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
        end else begin
            raw_q <= raw_d;
        end
    end

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
    import cpwm_pkg::*;
#(
    parameter int DT_W = DT_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw,
    input  logic [DT_W-1:0] dead_len,
    output logic            fall,
    output logic            gate,
    output logic [DT_W-1:0] remain
);

    logic            raw_prev;
    logic            len_nz;
    logic [DT_W-1:0] reload;

    always_comb begin
        fall   = raw_prev & ~raw;
        len_nz = |dead_len;
        reload = len_nz ? DT_W'(dead_len - 1'b1) : '0;
        // The cycle of the edge counts as the first dead cycle.
        gate   = ~(fall & len_nz) & (remain == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_prev <= 1'b0;
            remain   <= '0;
        end else begin
            raw_prev <= raw;
            if (fall) begin
                remain <= reload;
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpwm_polarity.sv
module cpwm_polarity
    import cpwm_pkg::*;
(
    input  leg_pair_t fin,
    input  logic      lvl_pos,
    input  logic      lvl_neg,
    output logic      pin_pos,
    output logic      pin_neg
);

    always_comb begin
        pin_pos = lvl_pos ? fin.pos : ~fin.pos;
        pin_neg = lvl_neg ? fin.neg : ~fin.neg;
    end

endmodule

// File: rtl/cpwm_phase_gen.sv
module cpwm_phase_gen
    import cpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int DT_W  = DT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tri_cnt,
    input  logic             cnt_up,
    input  logic [CNT_W-1:0] cmp_up,
    input  logic [CNT_W-1:0] cmp_mid,
    input  logic [CNT_W-1:0] cmp_dn,
    input  logic [DT_W-1:0]  dead_len,
    input  logic             lvl_pos,
    input  logic             lvl_neg,
    output logic             pwm_pos,
    output logic             pwm_neg
);

    leg_pair_t                  raw_q;
    logic [LEGS-1:0]            raw_v;
    logic [LEGS-1:0]            fall_v;
    logic [LEGS-1:0]            gate_v;
    logic [LEGS-1:0][DT_W-1:0]  remain_v;
    leg_pair_t                  fin_q;

    cpwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .tri_cnt (tri_cnt),
        .cnt_up  (cnt_up),
        .cmp_up  (cmp_up),
        .cmp_mid (cmp_mid),
        .cmp_dn  (cmp_dn),
        .raw_q   (raw_q)
    );

    assign raw_v[LEG_POS] = raw_q.pos;
    assign raw_v[LEG_NEG] = raw_q.neg;

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        cpwm_deadtime #(.DT_W(DT_W)) u_dt (
            .clk      (clk),
            .rst      (rst),
            .raw      (raw_v[g]),
            .dead_len (dead_len),
            .fall     (fall_v[g]),
            .gate     (gate_v[g]),
            .remain   (remain_v[g])
        );
    end

    // Each leg is gated by the dead-time window of the opposite leg.
    always_ff @(posedge clk) begin
        if (rst) begin
            fin_q <= '0;
        end else begin
            fin_q.pos <= raw_v[LEG_POS] & gate_v[LEG_NEG];
            fin_q.neg <= raw_v[LEG_NEG] & gate_v[LEG_POS];
        end
    end

    cpwm_polarity u_pol (
        .fin     (fin_q),
        .lvl_pos (lvl_pos),
        .lvl_neg (lvl_neg),
        .pin_pos (pwm_pos),
        .pin_neg (pwm_neg)
    );

endmodule

// File: rtl/cpwm_phase_chk.sv
module cpwm_phase_chk
    import cpwm_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int DT_W  = DT_W_DEF
) (
    input logic                      clk,
    input logic                      rst,
    input logic [CNT_W-1:0]          tri_cnt,
    input logic                      cnt_up,
    input logic [CNT_W-1:0]          cmp_up,
    input logic [CNT_W-1:0]          cmp_mid,
    input logic [CNT_W-1:0]          cmp_dn,
    input logic [DT_W-1:0]           dead_len,
    input logic [LEGS-1:0]           raw_v,
    input logic [LEGS-1:0]           fall_v,
    input logic [LEGS-1:0][DT_W-1:0] remain_v,
    input leg_pair_t                 fin_q
);

    a_r1_up_pos: assert property (@(posedge clk) disable iff (rst)
        cnt_up |=> raw_v[LEG_POS] == $past(tri_cnt >= cmp_up));

    a_r2_down_pos: assert property (@(posedge clk) disable iff (rst)
        !cnt_up |=> raw_v[LEG_POS] == $past(tri_cnt >= cmp_mid));

    a_r3_up_neg: assert property (@(posedge clk) disable iff (rst)
        cnt_up |=> raw_v[LEG_NEG] == $past(cmp_mid > tri_cnt));

    a_r4_down_neg: assert property (@(posedge clk) disable iff (rst)
        !cnt_up |=> raw_v[LEG_NEG] == $past(cmp_dn > tri_cnt));

    a_r6_pos_held: assert property (@(posedge clk) disable iff (rst)
        (fall_v[LEG_NEG] && dead_len != '0) |=> !fin_q.pos);

    a_r7_neg_held: assert property (@(posedge clk) disable iff (rst)
        (fall_v[LEG_POS] && dead_len != '0) |=> !fin_q.neg);

    a_r8_reload: assert property (@(posedge clk) disable iff (rst)
        (fall_v[LEG_POS] && dead_len != '0)
            |=> remain_v[LEG_POS] == DT_W'($past(dead_len) - 1'b1));

    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fin_q == '0 && remain_v[LEG_POS] == '0 && remain_v[LEG_NEG] == '0));

    a_r11_pos_needs_raw: assert property (@(posedge clk) disable iff (rst)
        fin_q.pos |-> $past(raw_v[LEG_POS]));

    a_r11_neg_needs_raw: assert property (@(posedge clk) disable iff (rst)
        fin_q.neg |-> $past(raw_v[LEG_NEG]));

endmodule

bind cpwm_phase_gen cpwm_phase_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tri_cnt  (tri_cnt),
    .cnt_up   (cnt_up),
    .cmp_up   (cmp_up),
    .cmp_mid  (cmp_mid),
    .cmp_dn   (cmp_dn),
    .dead_len (dead_len),
    .raw_v    (raw_v),
    .fall_v   (fall_v),
    .remain_v (remain_v),
    .fin_q    (fin_q)
);

// File: tb/test_cpwm_phase_gen.sv
`timescale 1ns/100ps
module test_cpwm_phase_gen;

    localparam int CW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] tri_cnt = '0;
    logic          cnt_up = 1'b1;
    logic [CW-1:0] cmp_up = 16'd10;
    logic [CW-1:0] cmp_mid = 16'd100;
    logic [CW-1:0] cmp_dn = 16'd50;
    logic [DW-1:0] dead_len = '0;
    logic          lvl_pos = 1'b1;
    logic          lvl_neg = 1'b1;
    logic          pwm_pos;
    logic          pwm_neg;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    cpwm_phase_gen #(.CNT_W(CW), .DT_W(DW)) i_cpwm_phase_gen (
        .clk      (clk),
        .rst      (rst),
        .tri_cnt  (tri_cnt),
        .cnt_up   (cnt_up),
        .cmp_up   (cmp_up),
        .cmp_mid  (cmp_mid),
        .cmp_dn   (cmp_dn),
        .dead_len (dead_len),
        .lvl_pos  (lvl_pos),
        .lvl_neg  (lvl_neg),
        .pwm_pos  (pwm_pos),
        .pwm_neg  (pwm_neg)
    );

    function automatic logic pin(input logic lvl, input logic v);
        return lvl ? v : ~v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic set_pt(input logic up, input int c);
        cnt_up  = up;
        tri_cnt = CW'(c);
    endtask

    // Hold one counter point long enough to settle, then check both pins.
    task automatic t_static(input string tag, input logic up, input int c,
                            input logic ep, input logic en);
        set_pt(up, c);
        tick(4);
        chk({tag, " pos"}, pwm_pos, pin(lvl_pos, ep));
        chk({tag, " neg"}, pwm_neg, pin(lvl_neg, en));
    endtask

    task automatic t_reset_state;
        tick(1);
        chk("R10 reset pos", pwm_pos, pin(lvl_pos, 1'b0));
        chk("R10 reset neg", pwm_neg, pin(lvl_neg, 1'b0));
        rst = 1'b0;
    endtask

    task automatic t_compare;
        dead_len = '0;
        t_static("R1 up below", 1'b1, 5,   1'b0, 1'b1);
        t_static("R1 up equal", 1'b1, 10,  1'b1, 1'b1);
        t_static("R3 up at mid", 1'b1, 100, 1'b1, 1'b0);
        t_static("R2 down below mid", 1'b0, 99, 1'b0, 1'b0);
        t_static("R2 down at mid", 1'b0, 100, 1'b1, 1'b0);
        t_static("R4 down below dn", 1'b0, 49, 1'b0, 1'b1);
        t_static("R4 down at dn", 1'b0, 50, 1'b0, 1'b0);
    endtask

    task automatic t_latency;
        dead_len = '0;
        set_pt(1'b0, 50);
        tick(4);
        set_pt(1'b1, 150);
        tick(1);
        chk("R5 after first edge", pwm_pos, pin(lvl_pos, 1'b0));
        tick(1);
        chk("R5 after second edge", pwm_pos, pin(lvl_pos, 1'b1));
    endtask

    // Negative leg falls while positive leg rises: positive pin waits L cycles.
    task automatic t_dead_pos(input int len);
        dead_len = DW'(len);
        set_pt(1'b0, 49);
        tick(len + 6);
        set_pt(1'b0, 100);
        tick(1);
        chk($sformatf("R6 L=%0d edge0", len), pwm_pos, pin(lvl_pos, 1'b0));
        for (int k = 1; k <= len + 2; k++) begin
            tick(1);
            chk($sformatf("R6 L=%0d k=%0d", len, k), pwm_pos, pin(lvl_pos, k > len));
            chk($sformatf("R6 L=%0d k=%0d neg", len, k), pwm_neg, pin(lvl_neg, 1'b0));
        end
    endtask

    task automatic t_dead_neg(input int len);
        dead_len = DW'(len);
        set_pt(1'b0, 100);
        tick(len + 6);
        set_pt(1'b0, 49);
        tick(1);
        chk($sformatf("R7 L=%0d edge0", len), pwm_neg, pin(lvl_neg, 1'b0));
        for (int k = 1; k <= len + 2; k++) begin
            tick(1);
            chk($sformatf("R7 L=%0d k=%0d", len, k), pwm_neg, pin(lvl_neg, k > len));
        end
    endtask

    task automatic t_restart;
        dead_len = DW'(4);
        set_pt(1'b0, 100);
        tick(10);
        set_pt(1'b0, 49);
        tick(2);
        set_pt(1'b0, 100);
        tick(1);
        set_pt(1'b0, 49);
        tick(1);
        for (int k = 1; k <= 6; k++) begin
            tick(1);
            chk($sformatf("R8 restart k=%0d", k), pwm_neg, pin(lvl_neg, k > 4));
        end
    endtask

    task automatic t_polarity;
        dead_len = '0;
        lvl_pos = 1'b0;
        lvl_neg = 1'b0;
        t_static("R9 inverted", 1'b1, 5, 1'b0, 1'b1);
        chk("R9 inverted pos level", pwm_pos, 1'b1);
        chk("R9 inverted neg level", pwm_neg, 1'b0);
        lvl_pos = 1'b1;
        tick(1);
        chk("R9 mixed pos level", pwm_pos, 1'b0);
        chk("R9 mixed neg level", pwm_neg, 1'b0);
        lvl_neg = 1'b1;
        tick(1);
        chk("R9 restored neg level", pwm_neg, 1'b1);
    endtask

    task automatic t_reset_mid_dead;
        dead_len = DW'(20);
        set_pt(1'b0, 49);
        tick(30);
        set_pt(1'b0, 100);
        tick(4);
        chk("R6 long window open", pwm_pos, pin(lvl_pos, 1'b0));
        rst = 1'b1;
        tick(1);
        chk("R10 in reset pos", pwm_pos, pin(lvl_pos, 1'b0));
        chk("R10 in reset neg", pwm_neg, pin(lvl_neg, 1'b0));
        rst = 1'b0;
        tick(1);
        chk("R10 release edge0", pwm_pos, pin(lvl_pos, 1'b0));
        tick(1);
        chk("R10 window dropped", pwm_pos, pin(lvl_pos, 1'b1));
        tick(1);
        chk("R11 neg stays off", pwm_neg, pin(lvl_neg, 1'b0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_compare();
        t_latency();
        t_dead_pos(3);
        t_dead_pos(1);
        t_dead_pos(0);
        t_dead_neg(3);
        t_dead_neg(0);
        t_restart();
        t_polarity();
        t_reset_mid_dead();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule